// File: doc/BRIEF.md
# Input Period Capture with Edge Masking Window

This block times an external pulse signal. A free-running period counter advances on every clock. When a selected transition of the input is accepted, the counter's value is copied into a capture register and the counter restarts at one. The captured number is therefore the count of clocks between two accepted transitions. The input passes through a two-flop synchronizer before any transition is detected. A compare value on the period counter gives a match strobe, for timeout or interval alarms.

Noise rejection is done by a small state machine with two states, `MASK_OPEN` and `MASK_HOLD`. In `MASK_OPEN`, transitions are accepted. If an accepted transition arrives while the noise enable is set, the `arm` transition moves the machine to `MASK_HOLD`. In that state a mask counter runs up from zero on every clock and every detected transition is discarded. When the mask counter equals the noise compare value, the `expire` transition returns the machine to `MASK_OPEN` and clears the counter.

An 8-bit event counter counts accepted transitions and pulses a match strobe when its new value equals an event compare value. When the trigger enable is set, the same strobe also goes out as a capture request to a neighbouring channel. The block has no bus access; all configuration arrives as static input ports.

Top module: `period_capture`

## Requirements
- R1: While rst_n is low, cap_value is 0, cap_valid, event_match and cap_req_out are 0, the period counter is 0 and the mask machine is in MASK_OPEN.
- R2: The 32-bit period counter rises by one on every clock and wraps. period_match is high in exactly those cycles where the counter equals period_cmp, so the first cycle after k clock edges out of reset shows a match when period_cmp equals k.
- R3: edge_sel encoding: 2'b00 accepts no transitions, 2'b01 accepts rising only, 2'b10 accepts falling only, 2'b11 accepts both. pulse_in goes through two flops before detection, so cap_valid is seen after the third rising clock edge that follows the input change.
- R4: On an accepted transition, cap_value takes the period counter's value and the counter is reloaded with 1. The capture therefore equals the number of clocks between two accepted transitions.
- R5: cap_valid is high for one cycle per accepted transition, in the same cycle that cap_value shows its new value. In any cycle where cap_valid is low, cap_value holds its value.
- R6: With noise_en set, an accepted transition starts a window that lasts noise_cmp+1 clocks. A transition detected inside the window is dropped: it makes no capture and no event count. A transition that follows the previous accepted one by more than noise_cmp+1 clocks is accepted.
- R7: With noise_en clear, no window is opened and every selected transition is accepted.
- R8: The 8-bit event counter counts accepted transitions and wraps after 255. event_match pulses for one cycle, together with cap_valid, when the new count equals event_cmp.
- R9: cap_req_out pulses in the cycle of event_match when trig_en is set, and stays low when trig_en is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pulse_in | input | 1 | Raw asynchronous pulse input |
| edge_sel | input | 2 | Transition selection (00 none, 01 rise, 10 fall, 11 both) |
| noise_en | input | 1 | Enables the masking window |
| noise_cmp | input | 8 | Mask counter terminal value |
| event_cmp | input | 8 | Event counter compare value |
| period_cmp | input | 32 | Period counter compare value |
| trig_en | input | 1 | Forwards event match as a capture request |
| cap_value | output | 32 | Last captured period |
| cap_valid | output | 1 | One-cycle capture strobe |
| period_match | output | 1 | Period counter equals period_cmp |
| event_match | output | 1 | One-cycle event compare strobe |
| cap_req_out | output | 1 | One-cycle capture request to another channel |

## Verification
A capture and an event-counter match can occur in the same cycle, since the transition that is captured is also the one that brings the event count to its compare value. With event_cmp set to 2 and the trigger enabled in some vectors, the bench drives pulse trains with a known number of accepted transitions. It checks that exactly one event match and the right number of capture requests appear. It also checks that every event match coincides with a capture strobe, and a wrap run of 257 transitions confirms that the match repeats after the counter rolls over. Masking vectors place transitions just inside and just outside the window, which shows that dropped transitions touch neither the capture nor the count.

// File: rtl/pc_pkg.sv
package pc_pkg;
    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_mode_e;

    typedef enum logic {
        MASK_OPEN = 1'b0,
        MASK_HOLD = 1'b1
    } mask_state_e;
endpackage

// File: rtl/pc_edge_detect.sv
module pc_edge_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       din,
    input  logic [1:0] sel,
    output logic       edge_hit
);
    import pc_pkg::*;

    logic [SYNC_STAGES-1:0] chain;
    logic                   prev;
    logic                   cur;
    logic                   rise;
    logic                   fall;

    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain[i] <= 1'b0;
                end else if (i == 0) begin
                    chain[i] <= din;
                end else begin
                    chain[i] <= chain[(i == 0) ? 0 : i-1];
                end
            end
        end
    endgenerate

    assign cur = chain[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= cur;
    end

    assign rise = cur & ~prev;
    assign fall = ~cur & prev;

    always_comb begin
        unique case (edge_mode_e'(sel))
            EDGE_OFF:  edge_hit = 1'b0;
            EDGE_RISE: edge_hit = rise;
            EDGE_FALL: edge_hit = fall;
            EDGE_BOTH: edge_hit = rise | fall;
        endcase
    end
endmodule

// File: rtl/pc_noise_mask.sv
module pc_noise_mask #(
    parameter int MASK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              noise_en,
    input  logic [MASK_W-1:0] noise_cmp,
    input  logic              accept,
    output logic              masking
);
    import pc_pkg::*;

    mask_state_e       state, state_nx;
    logic [MASK_W-1:0] mask_cnt;
    logic              expire;

    assign expire = (mask_cnt == noise_cmp);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= MASK_OPEN;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            MASK_OPEN: if (accept && noise_en) state_nx = MASK_HOLD;
            MASK_HOLD: if (expire)             state_nx = MASK_OPEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_cnt <= '0;
        end else if (state == MASK_HOLD) begin
            mask_cnt <= expire ? '0 : mask_cnt + 1'b1;
        end
    end

    always_comb begin
        masking = (state == MASK_HOLD);
    end
endmodule

// File: rtl/pc_event_counter.sv
module pc_event_counter #(
    parameter int EVT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic [EVT_W-1:0] event_cmp,
    input  logic             trig_en,
    output logic             event_match,
    output logic             cap_req_out
);
    logic [EVT_W-1:0] evt_cnt;
    logic [EVT_W-1:0] evt_nx;

    assign evt_nx = evt_cnt + 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_cnt     <= '0;
            event_match <= 1'b0;
            cap_req_out <= 1'b0;
        end else begin
            if (accept) evt_cnt <= evt_nx;
            event_match <= accept && (evt_nx == event_cmp);
            cap_req_out <= accept && (evt_nx == event_cmp) && trig_en;
        end
    end
endmodule

// File: rtl/period_capture.sv
module period_capture #(
    parameter int CNT_W       = 32,
    parameter int EVT_W       = 8,
    parameter int MASK_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pulse_in,
    input  logic [1:0]        edge_sel,
    input  logic              noise_en,
    input  logic [MASK_W-1:0] noise_cmp,
    input  logic [EVT_W-1:0]  event_cmp,
    input  logic [CNT_W-1:0]  period_cmp,
    input  logic              trig_en,
    output logic [CNT_W-1:0]  cap_value,
    output logic              cap_valid,
    output logic              period_match,
    output logic              event_match,
    output logic              cap_req_out
);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(1);

    logic             edge_hit;
    logic             masking;
    logic             accept;
    logic [CNT_W-1:0] period_cnt;

    pc_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (pulse_in),
        .sel      (edge_sel),
        .edge_hit (edge_hit)
    );

    assign accept = edge_hit & ~masking;

    pc_noise_mask #(.MASK_W(MASK_W)) u_mask (
        .clk       (clk),
        .rst_n     (rst_n),
        .noise_en  (noise_en),
        .noise_cmp (noise_cmp),
        .accept    (accept),
        .masking   (masking)
    );

    pc_event_counter #(.EVT_W(EVT_W)) u_evt (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .event_cmp   (event_cmp),
        .trig_en     (trig_en),
        .event_match (event_match),
        .cap_req_out (cap_req_out)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_cnt <= '0;
            cap_value  <= '0;
            cap_valid  <= 1'b0;
        end else begin
            cap_valid <= accept;
            if (accept) begin
                cap_value  <= period_cnt;
                period_cnt <= RELOAD;
            end else begin
                period_cnt <= period_cnt + 1'b1;
            end
        end
    end

    assign period_match = (period_cnt == period_cmp);
endmodule

// File: rtl/period_capture_chk.sv
module period_capture_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cap_valid,
    input logic [CNT_W-1:0] cap_value,
    input logic             event_match,
    input logic             cap_req_out,
    input logic [CNT_W-1:0] period_cnt,
    input logic             masking,
    input logic             edge_hit
);
    p_hold_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_valid |-> cap_value == $past(cap_value));

    p_reload_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid |-> period_cnt == CNT_W'(1));

    p_match_with_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
        event_match |-> cap_valid);

    p_req_follows_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cap_req_out |-> event_match);

    p_masked_edge_dropped_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (masking && edge_hit) |=> !cap_valid);
endmodule

bind period_capture period_capture_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cap_valid   (cap_valid),
    .cap_value   (cap_value),
    .event_match (event_match),
    .cap_req_out (cap_req_out),
    .period_cnt  (period_cnt),
    .masking     (masking),
    .edge_hit    (edge_hit)
);

// File: tb/period_capture_tb.sv
module period_capture_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pulse_in = 1'b0;
    logic [1:0]  edge_sel = 2'b00;
    logic        noise_en = 1'b0;
    logic [7:0]  noise_cmp = 8'd0;
    logic [7:0]  event_cmp = 8'd2;
    logic [31:0] period_cmp = 32'hFFFF_FFFF;
    logic        trig_en = 1'b0;
    logic [31:0] cap_value;
    logic        cap_valid;
    logic        period_match;
    logic        event_match;
    logic        cap_req_out;

    int n_chk = 0;
    int n_bad = 0;
    int n_cap = 0;
    int n_evm = 0;
    int n_req = 0;
    int n_orphan = 0;
    logic [31:0] last_cap = '0;

    always #10 clk = ~clk;

    period_capture u_dut (
        .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .edge_sel(edge_sel),
        .noise_en(noise_en), .noise_cmp(noise_cmp), .event_cmp(event_cmp),
        .period_cmp(period_cmp), .trig_en(trig_en), .cap_value(cap_value),
        .cap_valid(cap_valid), .period_match(period_match),
        .event_match(event_match), .cap_req_out(cap_req_out)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (cap_valid) begin
                n_cap    <= n_cap + 1;
                last_cap <= cap_value;
            end
            if (event_match) n_evm <= n_evm + 1;
            if (cap_req_out) n_req <= n_req + 1;
            if (event_match && !cap_valid) n_orphan <= n_orphan + 1;
        end
    end

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_counts();
        @(posedge clk);
        n_cap = 0; n_evm = 0; n_req = 0; n_orphan = 0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // sel, noise_en, trig_en, noise_cmp, high gap, low gap, captures, last capture
    localparam int NV = 8;
    localparam logic [83:0] VEC [NV] = '{
        {2'b01, 1'b0, 1'b1, 8'd0, 16'd7, 16'd9,  8'd3, 32'd16},
        {2'b10, 1'b0, 1'b0, 8'd0, 16'd5, 16'd12, 8'd2, 32'd17},
        {2'b11, 1'b0, 1'b1, 8'd0, 16'd4, 16'd6,  8'd5, 32'd6},
        {2'b00, 1'b0, 1'b1, 8'd0, 16'd5, 16'd5,  8'd0, 32'd0},
        {2'b11, 1'b1, 1'b1, 8'd4, 16'd3, 16'd20, 8'd3, 32'd23},
        {2'b11, 1'b1, 1'b0, 8'd4, 16'd5, 16'd20, 8'd3, 32'd25},
        {2'b11, 1'b1, 1'b0, 8'd4, 16'd6, 16'd20, 8'd5, 32'd20},
        {2'b01, 1'b1, 1'b1, 8'd3, 16'd2, 16'd2,  8'd2, 32'd8}
    };

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        pulse_in = 1'b0;
        wait_cyc(3);
        rst_n = 1'b1;
    endtask

    initial begin
        // R1: reset state
        wait_cyc(2);
        check("R1 cap_value", cap_value, 0);
        check("R1 cap_valid", cap_valid, 0);
        check("R1 event_match", event_match, 0);
        check("R1 cap_req_out", cap_req_out, 0);

        // Table-driven pulse trains (R3 R4 R5 R6 R7 R8 R9)
        for (int v = 0; v < NV; v++) begin
            logic [83:0] e;
            int hi, lo, ecnt, evm_exp;
            e = VEC[v];
            edge_sel  = e[83:82];
            noise_en  = e[81];
            trig_en   = e[80];
            noise_cmp = e[79:72];
            hi        = int'(e[71:56]);
            lo        = int'(e[55:40]);
            ecnt      = int'(e[39:32]);
            event_cmp = 8'd2;
            do_reset();
            wait_cyc(5);
            clear_counts();
            @(negedge clk);
            pulse_in = 1'b1; wait_cyc(hi);
            pulse_in = 1'b0; wait_cyc(lo);
            pulse_in = 1'b1; wait_cyc(hi);
            pulse_in = 1'b0; wait_cyc(lo);
            pulse_in = 1'b1; wait_cyc(12);
            check($sformatf("R3/R6/R7 capture count v%0d", v), n_cap, ecnt);
            if (ecnt > 0)
                check($sformatf("R4 last capture v%0d", v), last_cap, e[31:0]);
            evm_exp = (ecnt >= 2) ? 1 : 0;
            check($sformatf("R8 event match count v%0d", v), n_evm, evm_exp);
            check($sformatf("R9 capture request count v%0d", v), n_req, e[80] ? evm_exp : 0);
            check($sformatf("R8 match without capture v%0d", v), n_orphan, 0);
        end

        // R2: period match timing out of reset, no captures
        edge_sel = 2'b00;
        noise_en = 1'b0;
        period_cmp = 32'd50;
        do_reset();
        begin
            int hits, bad_pos;
            hits = 0; bad_pos = 0;
            for (int i = 1; i <= 60; i++) begin
                @(posedge clk); @(negedge clk);
                if (period_match) hits++;
                if (period_match != (i == 50)) bad_pos++;
            end
            check("R2 period match count", hits, 1);
            check("R2 period match position", bad_pos, 0);
        end

        // R3: latency of three clock edges from input change
        edge_sel = 2'b01;
        period_cmp = 32'hFFFF_FFFF;
        do_reset();
        wait_cyc(4);
        pulse_in = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R3 no strobe after 1 edge", cap_valid, 0);
        @(posedge clk); @(negedge clk);
        check("R3 no strobe after 2 edges", cap_valid, 0);
        @(posedge clk); @(negedge clk);
        check("R3 strobe after 3 edges", cap_valid, 1);
        @(posedge clk); @(negedge clk);
        check("R5 strobe lasts one cycle", cap_valid, 0);

        // R8: event counter wrap, compare 1 hit at events 1 and 257
        edge_sel = 2'b11;
        noise_en = 1'b0;
        event_cmp = 8'd1;
        trig_en = 1'b1;
        do_reset();
        wait_cyc(5);
        clear_counts();
        for (int k = 0; k < 257; k++) begin
            @(negedge clk);
            pulse_in = ~pulse_in;
            wait_cyc(2);
        end
        wait_cyc(10);
        check("R8 wrap capture count", n_cap, 257);
        check("R8 wrap match count", n_evm, 2);
        check("R9 wrap request count", n_req, 2);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule